// File: doc/BRIEF.md
# Privileged Interrupt Trap Arbiter

This block sits beside the control and status registers of a processor hart. Each cycle it looks at the current privilege level and the global interrupt enables. It also looks at the images of the pending, enable and delegation registers for the machine, supervisor and hypervisor levels. From these it decides whether an interrupt trap must be taken, whether the trap goes to machine mode or to the hypervisor-capable supervisor level, and which interrupt cause wins.

Interrupts that qualify for machine mode always win over those for the supervisor level. Within each level a fixed order of causes applies. The decision is registered, so it shows up one cycle after the inputs it was computed from.

A re-evaluate strobe comes from trap returns and from writes to the pending or enable registers. The strobe suppresses the decision for one cycle. The next decision is therefore always made on the updated register images. Trap selection for the virtualised supervisor level is not part of this block.

Top module: `intarb_top`

## Requirements
- R1: Bit i is a machine candidate when it is set in both the machine pending and machine enable images and clear in the machine delegation image.
- R2: Machine candidates may trap only when privMode is 2'b11 with mGie set, or when privMode is not 2'b11 (privMode 2'b01 = supervisor, 2'b00 = user).
- R3: Bit i is a supervisor candidate when it is set in both supervisor pending and enable, or in both hypervisor pending and enable, and clear in the hypervisor delegation image.
- R4: Supervisor candidates may trap only when the hart is not in machine mode and one of these holds: virtMode is set, privMode is user, or privMode is supervisor with sGie set.
- R5: If any qualifying machine candidate exists, the trap targets machine mode (trapTarget 2'b11), whatever supervisor candidates are present. Otherwise a qualifying supervisor candidate gives trapTarget 2'b01.
- R6: Among machine candidates the cause is the first present bit in the order 11, 3, 7, 9, 1, 5.
- R7: Among supervisor candidates the cause is the first present bit in the order 9, 1, 5.
- R8: Bit positions other than 1, 3, 5, 7, 9 and 11 never cause a trap.
- R9: trapValid, trapTarget and trapCause reflect the inputs sampled at the previous rising clock edge.
- R10: When reevalIn is high at a clock edge, trapValid is low in the following cycle. The next edge evaluates the then-current inputs.
- R11: During and right after reset, and whenever no trap is signalled, trapValid, trapTarget and trapCause are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| privMode | input | 2 | Current privilege: 11 machine, 01 supervisor, 00 user |
| virtMode | input | 1 | Hart runs virtualised (below the hypervisor supervisor level) |
| mGie | input | 1 | Machine global interrupt enable |
| sGie | input | 1 | Supervisor global interrupt enable |
| reevalIn | input | 1 | Re-evaluate strobe from trap return or register write |
| mPend | input | NumIrq | Machine pending image |
| mEna | input | NumIrq | Machine enable image |
| mDeleg | input | NumIrq | Machine delegation image |
| sPend | input | NumIrq | Supervisor pending image |
| sEna | input | NumIrq | Supervisor enable image |
| hPend | input | NumIrq | Hypervisor pending image |
| hEna | input | NumIrq | Hypervisor enable image |
| hDeleg | input | NumIrq | Hypervisor delegation image |
| trapValid | output | 1 | Take-trap strobe |
| trapTarget | output | 2 | Target mode: 11 machine, 01 supervisor |
| trapCause | output | $clog2(NumIrq) | Selected interrupt index |

## Verification
The re-evaluate strobe and a qualifying interrupt can fall in the same cycle. A machine interrupt and a supervisor interrupt can also qualify together. The bench raises reevalIn while a machine external interrupt is pending and expects no trap. On the next vector, with the strobe low, it expects the machine trap. Simultaneous machine and supervisor candidates are set up in both directed and random vectors. Every result is judged against a reference model built from the requirements, across all legal privilege and virtualisation combinations.

// File: rtl/intarb_pkg.sv
package intarb_pkg;
  localparam logic [1:0] MODE_U = 2'b00;
  localparam logic [1:0] MODE_S = 2'b01;
  localparam logic [1:0] MODE_M = 2'b11;

  localparam int M_ORDER_LEN = 6;
  localparam int S_ORDER_LEN = 3;
  localparam int M_ORDER [M_ORDER_LEN] = '{11, 3, 7, 9, 1, 5};
  localparam int S_ORDER [S_ORDER_LEN] = '{9, 1, 5};

  typedef struct packed {
    logic mOpen;
    logic sOpen;
    logic hold;
  } arbCtrl_t;
endpackage

// File: rtl/intarb_ctrl.sv
module intarb_ctrl
  import intarb_pkg::*;
(
  input  logic [1:0] privMode,
  input  logic       virtMode,
  input  logic       mGie,
  input  logic       sGie,
  input  logic       reevalIn,
  output arbCtrl_t   ctrl
);
  logic inMachine;
  logic inUser;
  logic inSuper;

  always_comb begin
    inMachine  = (privMode == MODE_M);
    inUser     = (privMode == MODE_U);
    inSuper    = (privMode == MODE_S) && !virtMode;
    // machine level opens when below machine or when machine has its enable set
    ctrl.mOpen = !inMachine || mGie;
    // supervisor level opens when strictly below it, or at it with its enable set
    ctrl.sOpen = !inMachine && (virtMode || inUser || (inSuper && sGie));
    ctrl.hold  = reevalIn;
  end
endmodule

// File: rtl/intarb_dp.sv
module intarb_dp
  import intarb_pkg::*;
#(
  parameter int NumIrq = 16,
  parameter int CauseW = $clog2(NumIrq)
) (
  input  logic              clk,
  input  logic              rstN,
  input  arbCtrl_t          ctrl,
  input  logic [NumIrq-1:0] mPend,
  input  logic [NumIrq-1:0] mEna,
  input  logic [NumIrq-1:0] mDeleg,
  input  logic [NumIrq-1:0] sPend,
  input  logic [NumIrq-1:0] sEna,
  input  logic [NumIrq-1:0] hPend,
  input  logic [NumIrq-1:0] hEna,
  input  logic [NumIrq-1:0] hDeleg,
  output logic              trapValid,
  output logic [1:0]        trapTarget,
  output logic [CauseW-1:0] trapCause
);
  logic [NumIrq-1:0] mStdMask;
  logic [NumIrq-1:0] sStdMask;
  logic [NumIrq-1:0] mCand;
  logic [NumIrq-1:0] sCand;
  logic [CauseW-1:0] mSel;
  logic [CauseW-1:0] sSel;
  logic              mAny;
  logic              sAny;

  for (genvar g = 0; g < NumIrq; g++) begin : g_mask
    assign mStdMask[g] = (g == 1) || (g == 3) || (g == 5) || (g == 7) || (g == 9) || (g == 11);
    assign sStdMask[g] = (g == 1) || (g == 5) || (g == 9);
  end

  always_comb begin
    mCand = mPend & mEna & ~mDeleg & mStdMask;
    sCand = ((sPend & sEna) | (hPend & hEna)) & ~hDeleg & sStdMask;
    mAny  = ctrl.mOpen && (|mCand);
    sAny  = ctrl.sOpen && (|sCand);
  end

  // walk each order from lowest to highest priority so the highest wins
  always_comb begin
    mSel = '0;
    for (int k = M_ORDER_LEN - 1; k >= 0; k--) begin
      if (mCand[M_ORDER[k]]) mSel = CauseW'(M_ORDER[k]);
    end
    sSel = '0;
    for (int k = S_ORDER_LEN - 1; k >= 0; k--) begin
      if (sCand[S_ORDER[k]]) sSel = CauseW'(S_ORDER[k]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trapValid  <= 1'b0;
      trapTarget <= 2'b00;
      trapCause  <= '0;
    end else if (ctrl.hold) begin
      trapValid  <= 1'b0;
      trapTarget <= 2'b00;
      trapCause  <= '0;
    end else if (mAny) begin
      trapValid  <= 1'b1;
      trapTarget <= MODE_M;
      trapCause  <= mSel;
    end else if (sAny) begin
      trapValid  <= 1'b1;
      trapTarget <= MODE_S;
      trapCause  <= sSel;
    end else begin
      trapValid  <= 1'b0;
      trapTarget <= 2'b00;
      trapCause  <= '0;
    end
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(ctrl.hold)) |-> !trapValid);

  p_machine_first_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(ctrl.hold) && $past(ctrl.mOpen) && ($past(mCand) != '0))
      |-> (trapValid && trapTarget == MODE_M));

  p_m_cause_pending_r1: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && trapValid && trapTarget == MODE_M)
      |-> ((($past(mCand) >> trapCause) & NumIrq'(1)) != '0));

  p_s_cause_pending_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && trapValid && trapTarget == MODE_S)
      |-> (((($past(sCand) >> trapCause) & NumIrq'(1)) != '0) && $past(ctrl.sOpen)));

  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    !trapValid |-> (trapTarget == 2'b00 && trapCause == '0));
endmodule

// File: rtl/intarb_top.sv
module intarb_top
  import intarb_pkg::*;
#(
  parameter int NumIrq = 16,
  localparam int CauseW = $clog2(NumIrq)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        privMode,
  input  logic              virtMode,
  input  logic              mGie,
  input  logic              sGie,
  input  logic              reevalIn,
  input  logic [NumIrq-1:0] mPend,
  input  logic [NumIrq-1:0] mEna,
  input  logic [NumIrq-1:0] mDeleg,
  input  logic [NumIrq-1:0] sPend,
  input  logic [NumIrq-1:0] sEna,
  input  logic [NumIrq-1:0] hPend,
  input  logic [NumIrq-1:0] hEna,
  input  logic [NumIrq-1:0] hDeleg,
  output logic              trapValid,
  output logic [1:0]        trapTarget,
  output logic [CauseW-1:0] trapCause
);
  arbCtrl_t ctrl;

  intarb_ctrl ctrl_i (
    .privMode (privMode),
    .virtMode (virtMode),
    .mGie     (mGie),
    .sGie     (sGie),
    .reevalIn (reevalIn),
    .ctrl     (ctrl)
  );

  intarb_dp #(.NumIrq(NumIrq), .CauseW(CauseW)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .mPend      (mPend),
    .mEna       (mEna),
    .mDeleg     (mDeleg),
    .sPend      (sPend),
    .sEna       (sEna),
    .hPend      (hPend),
    .hEna       (hEna),
    .hDeleg     (hDeleg),
    .trapValid  (trapValid),
    .trapTarget (trapTarget),
    .trapCause  (trapCause)
  );
endmodule

// File: tb/intarb_top_tb.sv
`timescale 1ns/1ps
module intarb_top_tb_top;
  localparam int N = 16;
  localparam int CW = $clog2(N);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] privMode = 2'b00;
  logic virtMode = 1'b0, mGie = 1'b0, sGie = 1'b0, reevalIn = 1'b0;
  logic [N-1:0] mPend = '0, mEna = '0, mDeleg = '0, sPend = '0, sEna = '0;
  logic [N-1:0] hPend = '0, hEna = '0, hDeleg = '0;
  logic trapValid;
  logic [1:0] trapTarget;
  logic [CW-1:0] trapCause;

  always #2.5 clk = ~clk;

  intarb_top #(.NumIrq(N)) dut_i (
    .clk(clk), .rstN(rstN), .privMode(privMode), .virtMode(virtMode),
    .mGie(mGie), .sGie(sGie), .reevalIn(reevalIn),
    .mPend(mPend), .mEna(mEna), .mDeleg(mDeleg), .sPend(sPend), .sEna(sEna),
    .hPend(hPend), .hEna(hEna), .hDeleg(hDeleg),
    .trapValid(trapValid), .trapTarget(trapTarget), .trapCause(trapCause)
  );

  typedef struct {
    logic          v;
    logic [1:0]    t;
    logic [CW-1:0] c;
    string         tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference built from the requirements
  function automatic exp_t refModel(logic [1:0] pm, logic vm, logic mg, logic sg, logic re,
      logic [N-1:0] mp, logic [N-1:0] me, logic [N-1:0] md,
      logic [N-1:0] sp, logic [N-1:0] se,
      logic [N-1:0] hp, logic [N-1:0] he, logic [N-1:0] hd, string tag);
    exp_t e;
    int mOrd[6] = '{11, 3, 7, 9, 1, 5};
    int sOrd[3] = '{9, 1, 5};
    logic [N-1:0] mc = mp & me & ~md;
    logic [N-1:0] sc = ((sp & se) | (hp & he)) & ~hd;
    logic mOk = (pm != 2'b11) || mg;
    logic sOk = (pm != 2'b11) && (vm || pm == 2'b00 || (pm == 2'b01 && sg));
    e.v = 0; e.t = 2'b00; e.c = '0; e.tag = tag;
    if (!re) begin
      if (mOk) begin
        for (int k = 0; k < 6; k++)
          if (!e.v && mc[mOrd[k]]) begin e.v = 1; e.t = 2'b11; e.c = CW'(mOrd[k]); end
      end
      if (!e.v && sOk) begin
        for (int k = 0; k < 3; k++)
          if (!e.v && sc[sOrd[k]]) begin e.v = 1; e.t = 2'b01; e.c = CW'(sOrd[k]); end
      end
    end
    return e;
  endfunction

  task automatic drive(logic [1:0] pm, logic vm, logic mg, logic sg, logic re,
      logic [N-1:0] mp, logic [N-1:0] me, logic [N-1:0] md,
      logic [N-1:0] sp, logic [N-1:0] se,
      logic [N-1:0] hp, logic [N-1:0] he, logic [N-1:0] hd, string tag);
    @(negedge clk);
    privMode = pm; virtMode = vm; mGie = mg; sGie = sg; reevalIn = re;
    mPend = mp; mEna = me; mDeleg = md; sPend = sp; sEna = se;
    hPend = hp; hEna = he; hDeleg = hd;
    q.push_back(refModel(pm, vm, mg, sg, re, mp, me, md, sp, se, hp, he, hd, tag));
  endtask

  task automatic mOnly(logic [1:0] pm, logic mg, logic [N-1:0] bits, string tag);
    drive(pm, 1'b0, mg, 1'b0, 1'b0, bits, bits, '0, '0, '0, '0, '0, '0, tag);
  endtask

  // monitor: compare one item per edge, sampled after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (trapValid !== e.v || trapTarget !== e.t || trapCause !== e.c) begin
          fails++;
          $display("FAIL %s: got v=%0b t=%b c=%0d, expected v=%0b t=%b c=%0d",
                   e.tag, trapValid, trapTarget, trapCause, e.v, e.t, e.c);
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [1:0] modes[5] = '{2'b11, 2'b01, 2'b00, 2'b01, 2'b00};
    logic       virts[5] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (trapValid !== 1'b0 || trapTarget !== 2'b00 || trapCause !== '0) begin
      fails++;
      $display("FAIL R11: got v=%0b t=%b c=%0d, expected zeros", trapValid, trapTarget, trapCause);
    end
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    checks++;
    if (trapValid !== 1'b0) begin
      fails++;
      $display("FAIL R11: got v=%0b after release, expected 0", trapValid);
    end

    // R1: delegation removes a machine candidate
    drive(2'b00, 0, 0, 0, 0, N'(1 << 7), N'(1 << 7), N'(1 << 7), '0, '0, '0, '0, '0, "R1");
    drive(2'b00, 0, 0, 0, 0, N'(1 << 7), N'(1 << 7), '0, '0, '0, '0, '0, '0, "R1");
    // R2: machine global enable
    mOnly(2'b11, 1'b0, N'(1 << 11), "R2");
    mOnly(2'b11, 1'b1, N'(1 << 11), "R2");
    mOnly(2'b01, 1'b0, N'(1 << 11), "R2");
    // R4: supervisor qualification
    drive(2'b01, 0, 0, 0, 0, '0, '0, '0, N'(1 << 9), N'(1 << 9), '0, '0, '0, "R4");
    drive(2'b01, 0, 0, 1, 0, '0, '0, '0, N'(1 << 9), N'(1 << 9), '0, '0, '0, "R4");
    drive(2'b11, 0, 1, 1, 0, '0, '0, '0, N'(1 << 9), N'(1 << 9), '0, '0, '0, "R4");
    drive(2'b01, 1, 0, 0, 0, '0, '0, '0, N'(1 << 9), N'(1 << 9), '0, '0, '0, "R4");
    // R3: hypervisor images and delegation
    drive(2'b00, 0, 0, 0, 0, '0, '0, '0, '0, '0, N'(1 << 5), N'(1 << 5), '0, "R3");
    drive(2'b00, 0, 0, 0, 0, '0, '0, '0, '0, '0, N'(1 << 5), N'(1 << 5), N'(1 << 5), "R3");
    // R5: machine beats supervisor
    drive(2'b00, 0, 0, 0, 0, N'(1 << 5), N'(1 << 5), '0, N'(1 << 9), N'(1 << 9), '0, '0, '0, "R5");
    // R6: machine order
    mOnly(2'b00, 1'b0, N'((1 << 3) | (1 << 7) | (1 << 9)), "R6");
    mOnly(2'b00, 1'b0, N'((1 << 7) | (1 << 9) | (1 << 1) | (1 << 5)), "R6");
    mOnly(2'b00, 1'b0, N'((1 << 9) | (1 << 1)), "R6");
    mOnly(2'b00, 1'b0, N'((1 << 1) | (1 << 5)), "R6");
    // R7: supervisor order
    drive(2'b00, 0, 0, 0, 0, '0, '0, '0, N'((1 << 1) | (1 << 5)), N'((1 << 1) | (1 << 5)), '0, '0, '0, "R7");
    drive(2'b00, 0, 0, 0, 0, '0, '0, '0, N'(1 << 5), N'(1 << 5), '0, '0, '0, "R7");
    drive(2'b00, 0, 0, 0, 0, '0, '0, '0, N'(16'h0222), N'(16'h0222), '0, '0, '0, "R7");
    // R8: non-standard positions
    drive(2'b00, 0, 1, 1, 0, N'(16'hF555), N'(16'hF555), '0, N'(16'hF555), N'(16'hF555),
          N'(16'hF555), N'(16'hF555), '0, "R8");
    // R10: re-evaluate strobe coinciding with a qualifying interrupt
    drive(2'b00, 0, 0, 0, 1, N'(1 << 11), N'(1 << 11), '0, '0, '0, '0, '0, '0, "R10");
    drive(2'b00, 0, 0, 0, 0, N'(1 << 11), N'(1 << 11), '0, '0, '0, '0, '0, '0, "R10");
    // R9: random images over all legal modes
    for (int i = 0; i < 300; i++) begin
      for (int m = 0; m < 5; m++) begin
        drive(modes[m], virts[m], 1'($urandom), 1'($urandom), 1'(($urandom % 8) == 0),
              N'($urandom & $urandom), N'($urandom | $urandom), N'($urandom & $urandom),
              N'($urandom), N'($urandom), N'($urandom & $urandom),
              N'($urandom), N'($urandom & $urandom), "R9");
      end
    end
    repeat (4) @(posedge clk);
    #1;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule